// File: doc/BRIEF.md
# Folded Branch History Register

This block keeps compressed copies of a long global branch-history shift register for one predictor table. The history covers the most recent `HIST_LEN` outcomes. Each copy folds that window down to a narrow width by XOR-ing together the history bits whose positions are congruent modulo the width. History position 0 is the newest outcome, and position `p` lands on folded bit `p mod W`. The block does not re-fold the whole history each cycle. Instead it updates every copy incrementally. It removes the contribution of the bits that leave the window, XORs in the new outcome, and rotates.

Each cycle the block accepts an update count of 0, 1 or 2 new history bits. It also takes a taken flag, which belongs only to the last of the new bits, since the earlier ones are always not-taken. Finally it takes the one or two oldest bits of the window, as read by the surrounding logic from the uncompressed history. Three copies are kept: one sized for the table index, one for the tag, and one a bit narrower for the tag's second term. From these copies and a PC-derived unhashed index, the block forms the table index and the tag combinationally.

Top module: `folded_hist_hash`

## Requirements
- R1: After reset, all three folded copies read zero.
- R2: With an update count of 0, every folded copy keeps its value. The taken flag and the oldest-bit inputs have no effect in that cycle.
- R3: With an update count of 1, each copy becomes the fold of the history shifted by one position, with the taken flag as the new newest bit.
- R4: With an update count of 2, the history advances by two positions. The older of the two new bits is not-taken and the newer one carries the taken flag. The update count never exceeds 2.
- R5: For a window longer than the fold width, the outgoing bits are cancelled. Input `old_bits_i[i]` holds history position `HIST_LEN-1-i`. Each copy stays equal to the direct fold of the last `HIST_LEN` outcomes over runs much longer than the window.
- R6: For a window no longer than the fold width, the copy equals the plain history, shifted left by the count with the taken flag in bit 0.
- R7: `tbl_idx_o` equals the low `ROWS_LOG` bits of `pc_idx_i` XOR the index copy. The index copy width is min(`HIST_LEN`, `ROWS_LOG`).
- R8: `tbl_tag_o` equals the low `TAG_LEN` bits of `pc_idx_i` XOR the tag copy XOR the narrow copy shifted left by one. The tag copy width is min(`HIST_LEN`, `TAG_LEN`), and the narrow copy width is min(`HIST_LEN`, `TAG_LEN-1`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_num_i | input | 2 | Number of history bits entering this cycle (0, 1 or 2) |
| upd_taken_i | input | 1 | Outcome of the last entering bit |
| old_bits_i | input | 2 | Bit i = history position HIST_LEN-1-i before the update |
| pc_idx_i | input | PC_W | Unhashed PC-derived index |
| idx_fold_o | output | min(HIST_LEN,ROWS_LOG) | Folded copy used for the index |
| tag_fold_o | output | min(HIST_LEN,TAG_LEN) | Folded copy used for the tag |
| alt_fold_o | output | min(HIST_LEN,TAG_LEN-1) | Narrow folded copy used for the tag |
| tbl_idx_o | output | ROWS_LOG | Hashed table index |
| tbl_tag_o | output | TAG_LEN | Hashed tag |

## Verification
The folded copies are registered, so an update driven in one cycle is visible on the fold outputs after the next rising edge. The index and tag are combinational from those registers and `pc_idx_i`, so they follow a PC change within the same cycle. The bench drives inputs on the falling edge. It checks fold results at the following falling edge, after exactly one rising edge. It checks hash results a short delay after changing the PC, with no clock in between. A reference shift register in the bench is advanced at the same falling edge, and the expected copies are folded directly from it for windows of 13, 8 and 119 bits.

// File: rtl/fh_pkg.sv
package fh_pkg;

    function automatic int min_int(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int MAX_NEW_BITS = 2;

endpackage

// File: rtl/fh_fold_unit.sv
module fh_fold_unit #(
    parameter int HIST_LEN = 13,
    parameter int FOLD_W   = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [1:0]        num_i,
    input  logic              taken_i,
    input  logic [1:0]        oldest_i,
    output logic [FOLD_W-1:0] fold_o
);
    typedef struct packed {
        logic [FOLD_W-1:0] fold;
    } fold_state_t;

    fold_state_t st_d, st_q;

    generate
        if (HIST_LEN > FOLD_W) begin : g_wrap
            logic [FOLD_W-1:0]   mixed;
            logic [2*FOLD_W-1:0] doubled;

            always_comb begin
                mixed = st_q.fold;
                // drop current bits whose history position leaves entirely
                for (int j = 0; j < FOLD_W; j++) begin
                    if (int'(num_i) >= HIST_LEN - j) mixed[j] = 1'b0;
                end
                // cancel outgoing bits that were folded onto a wrapped slot
                for (int i = 0; i < fh_pkg::MAX_NEW_BITS; i++) begin
                    if ((HIST_LEN - 1 - i >= FOLD_W) && (i < int'(num_i)))
                        mixed[(HIST_LEN - 1 - i) % FOLD_W] ^= oldest_i[i];
                end
                // newest bit lands in the slot that rotates into bit 0
                for (int i = 0; i < fh_pkg::MAX_NEW_BITS; i++) begin
                    if (int'(num_i) == i + 1)
                        mixed[FOLD_W - 1 - i] ^= taken_i;
                end
                doubled = {mixed, mixed};
                st_d = st_q;
                case (num_i)
                    2'd1:    st_d.fold = doubled[2*FOLD_W-2 -: FOLD_W];
                    2'd2:    st_d.fold = doubled[2*FOLD_W-3 -: FOLD_W];
                    default: st_d.fold = st_q.fold;
                endcase
            end
        end else begin : g_plain
            logic unused_oldest;
            assign unused_oldest = ^oldest_i;

            always_comb begin
                st_d = st_q;
                if (num_i != 2'd0)
                    st_d.fold = (st_q.fold << num_i) | {{(FOLD_W-1){1'b0}}, taken_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign fold_o = st_q.fold;
endmodule

// File: rtl/fh_hash.sv
module fh_hash #(
    parameter int PC_W     = 16,
    parameter int ROWS_LOG = 11,
    parameter int TAG_LEN  = 8,
    parameter int IDX_FW   = 11,
    parameter int TAG_FW   = 8,
    parameter int ALT_FW   = 7
) (
    input  logic [PC_W-1:0]     pc_idx_i,
    input  logic [IDX_FW-1:0]   idx_fold_i,
    input  logic [TAG_FW-1:0]   tag_fold_i,
    input  logic [ALT_FW-1:0]   alt_fold_i,
    output logic [ROWS_LOG-1:0] idx_o,
    output logic [TAG_LEN-1:0]  tag_o
);
    localparam int WIDE = fh_pkg::max_int(fh_pkg::max_int(PC_W, ROWS_LOG),
                                          fh_pkg::max_int(TAG_LEN, ALT_FW + 1)) + 1;

    logic [WIDE-1:0] pc_w, idx_mix, tag_mix;
    logic            unused_hi;

    always_comb begin
        pc_w    = WIDE'(pc_idx_i);
        idx_mix = pc_w ^ WIDE'(idx_fold_i);
        tag_mix = pc_w ^ WIDE'(tag_fold_i) ^ (WIDE'(alt_fold_i) << 1);
    end

    assign idx_o     = idx_mix[ROWS_LOG-1:0];
    assign tag_o     = tag_mix[TAG_LEN-1:0];
    assign unused_hi = ^{idx_mix[WIDE-1:ROWS_LOG], tag_mix[WIDE-1:TAG_LEN]};
endmodule

// File: rtl/folded_hist_hash.sv
module folded_hist_hash
    import fh_pkg::*;
#(
    parameter int HIST_LEN = 13,
    parameter int ROWS_LOG = 11,
    parameter int TAG_LEN  = 8,
    parameter int PC_W     = 16
) (
    input  logic                                    clk_i,
    input  logic                                    rst_ni,
    input  logic [1:0]                              upd_num_i,
    input  logic                                    upd_taken_i,
    input  logic [1:0]                              old_bits_i,
    input  logic [PC_W-1:0]                         pc_idx_i,
    output logic [min_int(HIST_LEN,ROWS_LOG)-1:0]   idx_fold_o,
    output logic [min_int(HIST_LEN,TAG_LEN)-1:0]    tag_fold_o,
    output logic [min_int(HIST_LEN,TAG_LEN-1)-1:0]  alt_fold_o,
    output logic [ROWS_LOG-1:0]                     tbl_idx_o,
    output logic [TAG_LEN-1:0]                      tbl_tag_o
);
    localparam int IDX_FW = min_int(HIST_LEN, ROWS_LOG);
    localparam int TAG_FW = min_int(HIST_LEN, TAG_LEN);
    localparam int ALT_FW = min_int(HIST_LEN, TAG_LEN - 1);

    fh_fold_unit #(.HIST_LEN(HIST_LEN), .FOLD_W(IDX_FW)) u_idx_fold (
        .clk_i(clk_i), .rst_ni(rst_ni), .num_i(upd_num_i), .taken_i(upd_taken_i),
        .oldest_i(old_bits_i), .fold_o(idx_fold_o)
    );

    fh_fold_unit #(.HIST_LEN(HIST_LEN), .FOLD_W(TAG_FW)) u_tag_fold (
        .clk_i(clk_i), .rst_ni(rst_ni), .num_i(upd_num_i), .taken_i(upd_taken_i),
        .oldest_i(old_bits_i), .fold_o(tag_fold_o)
    );

    fh_fold_unit #(.HIST_LEN(HIST_LEN), .FOLD_W(ALT_FW)) u_alt_fold (
        .clk_i(clk_i), .rst_ni(rst_ni), .num_i(upd_num_i), .taken_i(upd_taken_i),
        .oldest_i(old_bits_i), .fold_o(alt_fold_o)
    );

    fh_hash #(
        .PC_W(PC_W), .ROWS_LOG(ROWS_LOG), .TAG_LEN(TAG_LEN),
        .IDX_FW(IDX_FW), .TAG_FW(TAG_FW), .ALT_FW(ALT_FW)
    ) u_hash (
        .pc_idx_i(pc_idx_i), .idx_fold_i(idx_fold_o), .tag_fold_i(tag_fold_o),
        .alt_fold_i(alt_fold_o), .idx_o(tbl_idx_o), .tag_o(tbl_tag_o)
    );
endmodule

// File: rtl/folded_hist_hash_chk.sv
module folded_hist_hash_chk
    import fh_pkg::*;
#(
    parameter int HIST_LEN = 13,
    parameter int ROWS_LOG = 11,
    parameter int TAG_LEN  = 8,
    parameter int PC_W     = 16
) (
    input logic                                    clk_i,
    input logic                                    rst_ni,
    input logic [1:0]                              upd_num_i,
    input logic                                    upd_taken_i,
    input logic [1:0]                              old_bits_i,
    input logic [min_int(HIST_LEN,ROWS_LOG)-1:0]   idx_fold_o,
    input logic [min_int(HIST_LEN,TAG_LEN)-1:0]    tag_fold_o,
    input logic [min_int(HIST_LEN,TAG_LEN-1)-1:0]  alt_fold_o
);
    // R4: the count is limited to two new bits
    p_num_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_num_i <= 2'd2);

    // R2: no update leaves every copy unchanged
    p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_num_i == 2'd0) |=> ($stable(idx_fold_o) && $stable(tag_fold_o) && $stable(alt_fold_o)));

    // R5: an all-zero window fed with zeros stays zero
    p_zero_stays_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((idx_fold_o == '0) && !upd_taken_i && (old_bits_i == 2'b00)) |=> (idx_fold_o == '0));

    // R3: parity of a fold tracks the entering and leaving bits
    p_idx_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_num_i == 2'd1) |=> ((^idx_fold_o) == $past((^idx_fold_o) ^ upd_taken_i ^ old_bits_i[0])));

    p_tag_parity_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_num_i == 2'd1) |=> ((^tag_fold_o) == $past((^tag_fold_o) ^ upd_taken_i ^ old_bits_i[0])));

    // R4: two-bit advance removes both outgoing bits
    p_idx_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_num_i == 2'd2) |=> ((^idx_fold_o) == $past((^idx_fold_o) ^ upd_taken_i ^ (^old_bits_i))));

    p_alt_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upd_num_i == 2'd2) |=> ((^alt_fold_o) == $past((^alt_fold_o) ^ upd_taken_i ^ (^old_bits_i))));
endmodule

bind folded_hist_hash folded_hist_hash_chk #(
    .HIST_LEN(HIST_LEN), .ROWS_LOG(ROWS_LOG), .TAG_LEN(TAG_LEN), .PC_W(PC_W)
) chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .upd_num_i(upd_num_i), .upd_taken_i(upd_taken_i),
    .old_bits_i(old_bits_i), .idx_fold_o(idx_fold_o), .tag_fold_o(tag_fold_o),
    .alt_fold_o(alt_fold_o)
);

// File: tb/folded_hist_hash_tb_top.sv
`timescale 1ns/1ps
module folded_hist_hash_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  num = 2'd0;
    logic        taken = 1'b0;
    logic [1:0]  junk = 2'b00;
    logic [15:0] pc = 16'h0;
    logic [127:0] ghr = '0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    logic [1:0] old_a, old_b, old_c;
    assign old_a = {ghr[11], ghr[12]} ^ junk;
    assign old_b = {ghr[6], ghr[7]} ^ junk;
    assign old_c = {ghr[117], ghr[118]} ^ junk;

    logic [10:0] a_idx, c_idx;
    logic [7:0]  b_idx, a_tag, b_tag, c_tag, a_ttag, b_ttag, c_ttag;
    logic [6:0]  a_alt, b_alt, c_alt;
    logic [10:0] a_tidx, b_tidx, c_tidx;

    folded_hist_hash #(.HIST_LEN(13)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .upd_num_i(num), .upd_taken_i(taken),
        .old_bits_i(old_a), .pc_idx_i(pc), .idx_fold_o(a_idx), .tag_fold_o(a_tag),
        .alt_fold_o(a_alt), .tbl_idx_o(a_tidx), .tbl_tag_o(a_ttag));

    folded_hist_hash #(.HIST_LEN(8)) dut_short_i (
        .clk_i(clk), .rst_ni(rst_n), .upd_num_i(num), .upd_taken_i(taken),
        .old_bits_i(old_b), .pc_idx_i(pc), .idx_fold_o(b_idx), .tag_fold_o(b_tag),
        .alt_fold_o(b_alt), .tbl_idx_o(b_tidx), .tbl_tag_o(b_ttag));

    folded_hist_hash #(.HIST_LEN(119)) dut_long_i (
        .clk_i(clk), .rst_ni(rst_n), .upd_num_i(num), .upd_taken_i(taken),
        .old_bits_i(old_c), .pc_idx_i(pc), .idx_fold_o(c_idx), .tag_fold_o(c_tag),
        .alt_fold_o(c_alt), .tbl_idx_o(c_tidx), .tbl_tag_o(c_ttag));

    function automatic logic [15:0] ref_fold(input int l, input int c);
        logic [15:0] f = '0;
        for (int p = 0; p < l; p++) f[p % c] ^= ghr[p];
        return f;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_folds(input string req);
        chk({req, " L13 idx"}, 32'(a_idx), 32'(ref_fold(13, 11)));
        chk({req, " L13 tag"}, 32'(a_tag), 32'(ref_fold(13, 8)));
        chk({req, " L13 alt"}, 32'(a_alt), 32'(ref_fold(13, 7)));
        chk({req, " L8 idx"},  32'(b_idx), 32'(ref_fold(8, 8)));
        chk({req, " L8 tag"},  32'(b_tag), 32'(ref_fold(8, 8)));
        chk({req, " L8 alt"},  32'(b_alt), 32'(ref_fold(8, 7)));
        chk({req, " L119 idx"}, 32'(c_idx), 32'(ref_fold(119, 11)));
        chk({req, " L119 tag"}, 32'(c_tag), 32'(ref_fold(119, 8)));
        chk({req, " L119 alt"}, 32'(c_alt), 32'(ref_fold(119, 7)));
    endtask

    // one update: inputs at falling edge, result one rising edge later
    task automatic step(input logic [1:0] n, input logic t);
        num = n;
        taken = t;
        @(posedge clk);
        @(negedge clk);
        for (int k = 0; k < int'(n); k++)
            ghr = {ghr[126:0], (k == int'(n) - 1) ? t : 1'b0};
        num = 2'd0;
        taken = 1'b0;
    endtask

    task automatic t_reset;
        chk_folds("R1");
    endtask

    task automatic t_hold;
        for (int k = 0; k < 6; k++) step(2'd1, 1'b1);
        junk = 2'b11;
        step(2'd0, 1'b1);
        chk_folds("R2");
        step(2'd0, 1'b0);
        chk_folds("R2");
        junk = 2'b00;
    endtask

    task automatic t_single;
        logic [7:0] pat = 8'b1011_0010;
        for (int k = 0; k < 8; k++) begin
            step(2'd1, pat[k]);
            chk_folds("R3");
        end
    endtask

    task automatic t_double;
        for (int k = 0; k < 8; k++) begin
            step(2'd2, k[0]);
            chk_folds("R4");
        end
    endtask

    task automatic t_short_window;
        for (int k = 0; k < 20; k++) begin
            step(2'((k % 2) + 1), k[1]);
            chk({"R6 L8 tag"}, 32'(b_tag), 32'(ghr[7:0]));
        end
    endtask

    task automatic t_long_run;
        for (int k = 0; k < 400; k++) begin
            logic [1:0] n = 2'($urandom_range(0, 2));
            logic t = (n != 2'd0) ? 1'($urandom_range(0, 1)) : 1'b0;
            step(n, t);
            chk_folds("R5");
        end
    endtask

    task automatic t_hash;
        for (int k = 0; k < 6; k++) begin
            logic [15:0] e16;
            pc = 16'($urandom);
            #1;
            e16 = pc ^ ref_fold(13, 11);
            chk("R7 L13 idx", 32'(a_tidx), 32'(e16[10:0]));
            e16 = pc ^ ref_fold(119, 11);
            chk("R7 L119 idx", 32'(c_tidx), 32'(e16[10:0]));
            e16 = pc ^ ref_fold(8, 8);
            chk("R7 L8 idx", 32'(b_tidx), 32'(e16[10:0]));
            e16 = pc ^ ref_fold(13, 8) ^ (ref_fold(13, 7) << 1);
            chk("R8 L13 tag", 32'(a_ttag), 32'(e16[7:0]));
            e16 = pc ^ ref_fold(8, 8) ^ (ref_fold(8, 7) << 1);
            chk("R8 L8 tag", 32'(b_ttag), 32'(e16[7:0]));
            e16 = pc ^ ref_fold(119, 8) ^ (ref_fold(119, 7) << 1);
            chk("R8 L119 tag", 32'(c_ttag), 32'(e16[7:0]));
            step(2'd1, 1'b1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hold();
        t_single();
        t_double();
        t_short_window();
        t_long_run();
        t_hash();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule